// File: doc/BRIEF.md
# Debug Instruction Stuffing Engine

This block feeds a single 32-bit opcode into a halted core through its external debug port. It writes the opcode into the core's instruction-transfer register. It then reads the debug status/control register over and over until the core reports either completion or an error.

An error does not end the command. The block first drops memory-access mode if that mode is on. It then clears the sticky error through the reserve-control register and starts another attempt. The number of attempts is bounded. A single deadline, counted in clock cycles from the start of the command, can stop the whole command.

The caller supplies a status code together with each command. If that code already marks a failure, the block touches no register and returns the code unchanged. This lets a chain of commands carry the first failure through to the end. All register traffic goes over one simple request/acknowledge bus master port with 32-bit accesses.

Top module: `dbg_instr_stuffer`

## Requirements
- R1: After reset, `done_o` is low and `bus_req_o` is low until a command starts.
- R2: A start whose `status_in_i` has its MSB set (an error code) produces `done_o` on the next cycle with `status_o` equal to `status_in_i`, and no bus access is made.
- R3: Each attempt begins with a write of the latched opcode to offset 0x084, followed by reads of offset 0x088.
- R4: A status read with bit 24 set ends the command with `status_o` equal to the incoming status. Bit 24 wins over bit 6 in the same read.
- R5: A status read with bit 6 set and bit 20 set is followed by a write to 0x088 of that read value with bit 20 cleared. With bit 20 clear, no write to 0x088 is made.
- R6: After every error read, the block writes 0x0000_0004 to offset 0x090 and then starts a new attempt, beginning with the opcode write.
- R7: Once `MAX_RETRY` (16) attempts have all ended in error, the command finishes with `status_o` = 3'b111.
- R8: The cycle counter starts from zero at each command start and does not restart on retries. A status read without bit 24, taken once that counter has reached `timeout_i`, ends the command at once with `status_o` = 3'b110. No further opcode write follows. A timeout of 0 still lets a completing first read succeed.
- R9: While `bus_req_o` is high and `bus_ack_i` is low, the request's address, write flag and write data stay stable.
- R10: `done_o` is a one-cycle pulse. A `start_i` that arrives while a command is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Command start strobe, taken when idle |
| opcode_i | input | 32 | Opcode to inject |
| timeout_i | input | TMO_W | Deadline in cycles from start |
| status_in_i | input | STAT_W | Incoming status; MSB set marks an error |
| done_o | output | 1 | One-cycle completion pulse |
| status_o | output | STAT_W | Resulting status, valid with and after done_o |
| bus_req_o | output | 1 | Bus request, held until acknowledged |
| bus_we_o | output | 1 | 1 for write, 0 for read |
| bus_addr_o | output | ADDR_W | Register byte offset |
| bus_wdata_o | output | 32 | Write data |
| bus_ack_i | input | 1 | Bus acknowledge; read data valid with it |
| bus_rdata_i | input | 32 | Read data |

## Verification
A retry counter with a wrong value would show up in the result: the command would end as an instruction error after the wrong number of opcode writes, and the counts of opcode and reserve-control writes at the bus would disagree with the number of scripted errors. That becomes visible no later than the final `done_o` pulse. A wrong latched error value would appear as soon as the status/control write-back happens. A deadline counter that restarts on each retry would turn an expected timeout into an instruction error, so the mismatch shows up in `status_o` when the command ends. A state machine stuck after an acknowledge leaves `done_o` low forever.

// File: rtl/dsi_pkg.sv
package dsi_pkg;
    localparam int unsigned OFF_ITR  = 32'h084;
    localparam int unsigned OFF_SCR  = 32'h088;
    localparam int unsigned OFF_RCR  = 32'h090;
    localparam int unsigned BIT_DONE = 24;
    localparam int unsigned BIT_ERR  = 6;
    localparam int unsigned BIT_MACC = 20;
    localparam int unsigned BIT_CLR  = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_OP,
        ST_RD_SCR,
        ST_WR_SCR,
        ST_WR_RCR,
        ST_DONE
    } dsi_state_e;
endpackage

// File: rtl/dsi_timer.sv
module dsi_timer #(
    parameter int TMO_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             en_i,
    input  logic [TMO_W-1:0] limit_i,
    output logic             expired_o
);
    localparam logic [TMO_W-1:0] CNT_MAX = '1;

    logic [TMO_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)
            cnt_d = '0;
        else if (en_i && cnt_q != CNT_MAX)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired_o = (cnt_q >= limit_i);

    // R8: the deadline count only moves forward inside a command
    p_tmr_mono_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && en_i) |=> (cnt_q >= $past(cnt_q)));
endmodule

// File: rtl/dsi_retry.sv
module dsi_retry #(
    parameter int MAX_RETRY = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic inc_i,
    output logic last_o
);
    localparam int CW = $clog2(MAX_RETRY + 1);
    localparam logic [CW-1:0] LAST = CW'(MAX_RETRY - 1);
    localparam logic [CW-1:0] TOP  = CW'(MAX_RETRY);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)
            cnt_d = '0;
        else if (inc_i && cnt_q != TOP)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign last_o = (cnt_q == LAST);

    // R7: the failed-attempt count never passes the bound
    p_retry_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= TOP);
endmodule

// File: rtl/dbg_instr_stuffer.sv
module dbg_instr_stuffer
    import dsi_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int TMO_W     = 20,
    parameter int STAT_W    = 3,
    parameter int MAX_RETRY = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [31:0]       opcode_i,
    input  logic [TMO_W-1:0]  timeout_i,
    input  logic [STAT_W-1:0] status_in_i,
    output logic              done_o,
    output logic [STAT_W-1:0] status_o,
    output logic              bus_req_o,
    output logic              bus_we_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [31:0]       bus_wdata_o,
    input  logic              bus_ack_i,
    input  logic [31:0]       bus_rdata_i
);
    localparam logic [STAT_W-1:0] STAT_ERR = '1;
    localparam logic [STAT_W-1:0] STAT_TMO = STAT_ERR - 1'b1;
    localparam logic [ADDR_W-1:0] A_ITR    = ADDR_W'(OFF_ITR);
    localparam logic [ADDR_W-1:0] A_SCR    = ADDR_W'(OFF_SCR);
    localparam logic [ADDR_W-1:0] A_RCR    = ADDR_W'(OFF_RCR);
    localparam logic [31:0]       MACC_M   = 32'd1 << BIT_MACC;
    localparam logic [31:0]       CLR_W    = 32'd1 << BIT_CLR;

    typedef struct packed {
        dsi_state_e        state;
        logic [31:0]       opcode;
        logic [STAT_W-1:0] stat;
        logic [TMO_W-1:0]  limit;
        logic [31:0]       scr;
    } regs_t;

    regs_t d, q;
    logic  tmr_clr, tmr_expired, rty_clr, rty_inc, rty_last;

    dsi_timer #(.TMO_W(TMO_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (tmr_clr),
        .en_i      (q.state != ST_IDLE),
        .limit_i   (q.limit),
        .expired_o (tmr_expired)
    );

    dsi_retry #(.MAX_RETRY(MAX_RETRY)) u_retry (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (rty_clr),
        .inc_i  (rty_inc),
        .last_o (rty_last)
    );

    always_comb begin
        d           = q;
        tmr_clr     = 1'b0;
        rty_clr     = 1'b0;
        rty_inc     = 1'b0;
        bus_req_o   = 1'b0;
        bus_we_o    = 1'b0;
        bus_addr_o  = A_SCR;
        bus_wdata_o = '0;
        unique case (q.state)
            ST_IDLE: begin
                if (start_i) begin
                    d.opcode = opcode_i;
                    d.stat   = status_in_i;
                    d.limit  = timeout_i;
                    tmr_clr  = 1'b1;
                    rty_clr  = 1'b1;
                    d.state  = status_in_i[STAT_W-1] ? ST_DONE : ST_WR_OP;
                end
            end
            ST_WR_OP: begin
                bus_req_o   = 1'b1;
                bus_we_o    = 1'b1;
                bus_addr_o  = A_ITR;
                bus_wdata_o = q.opcode;
                if (bus_ack_i) d.state = ST_RD_SCR;
            end
            ST_RD_SCR: begin
                bus_req_o  = 1'b1;
                bus_addr_o = A_SCR;
                if (bus_ack_i) begin
                    if (bus_rdata_i[BIT_DONE]) begin
                        d.state = ST_DONE;
                    end else if (tmr_expired) begin
                        d.stat  = STAT_TMO;
                        d.state = ST_DONE;
                    end else if (bus_rdata_i[BIT_ERR]) begin
                        d.scr   = bus_rdata_i;
                        d.state = bus_rdata_i[BIT_MACC] ? ST_WR_SCR : ST_WR_RCR;
                    end
                end
            end
            ST_WR_SCR: begin
                bus_req_o   = 1'b1;
                bus_we_o    = 1'b1;
                bus_addr_o  = A_SCR;
                bus_wdata_o = q.scr & ~MACC_M;
                if (bus_ack_i) d.state = ST_WR_RCR;
            end
            ST_WR_RCR: begin
                bus_req_o   = 1'b1;
                bus_we_o    = 1'b1;
                bus_addr_o  = A_RCR;
                bus_wdata_o = CLR_W;
                if (bus_ack_i) begin
                    rty_inc = 1'b1;
                    if (rty_last) begin
                        d.stat  = STAT_ERR;
                        d.state = ST_DONE;
                    end else begin
                        d.state = ST_WR_OP;
                    end
                end
            end
            ST_DONE: d.state = ST_IDLE;
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state  <= ST_IDLE;
            q.opcode <= '0;
            q.stat   <= '0;
            q.limit  <= '0;
            q.scr    <= '0;
        end else begin
            q <= d;
        end
    end

    assign done_o   = (q.state == ST_DONE);
    assign status_o = q.stat;

    // R2: an incoming error code is returned on the next cycle
    p_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_IDLE && start_i && status_in_i[STAT_W-1])
        |=> (done_o && status_o == $past(status_in_i)));
    // R1: completion never overlaps a bus request
    p_done_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !bus_req_o);
    // R5: a status write-back never carries memory-access mode
    p_ma_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_o && bus_we_o && bus_addr_o == A_SCR) |-> !bus_wdata_o[BIT_MACC]);
    // R6: the reserve-control write is only the clear-error bit
    p_rcr_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_o && bus_we_o && bus_addr_o == A_RCR) |-> bus_wdata_o == CLR_W);
    // R9: a pending request is held stable
    p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_o && !bus_ack_i) |=> (bus_req_o && $stable(bus_addr_o)
            && $stable(bus_we_o) && $stable(bus_wdata_o)));
    // R10: completion lasts one cycle
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
endmodule

// File: tb/tb_dbg_instr_stuffer.sv
module tb_dbg_instr_stuffer;
    localparam int ADDR_W = 12;
    localparam int TMO_W  = 20;
    localparam int STAT_W = 3;
    localparam logic [STAT_W-1:0] S_TMO = 3'b110;
    localparam logic [STAT_W-1:0] S_ERR = 3'b111;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic [31:0] opcode_i = '0;
    logic [TMO_W-1:0] timeout_i = '0;
    logic [STAT_W-1:0] status_in_i = '0;
    logic done_o, bus_req_o, bus_we_o;
    logic [STAT_W-1:0] status_o;
    logic [ADDR_W-1:0] bus_addr_o;
    logic [31:0] bus_wdata_o;
    logic bus_ack_i = 1'b0;
    logic [31:0] bus_rdata_i = '0;

    always #4 clk = ~clk;

    dbg_instr_stuffer #(.ADDR_W(ADDR_W), .TMO_W(TMO_W), .STAT_W(STAT_W), .MAX_RETRY(16)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .opcode_i(opcode_i),
        .timeout_i(timeout_i), .status_in_i(status_in_i), .done_o(done_o),
        .status_o(status_o), .bus_req_o(bus_req_o), .bus_we_o(bus_we_o),
        .bus_addr_o(bus_addr_o), .bus_wdata_o(bus_wdata_o),
        .bus_ack_i(bus_ack_i), .bus_rdata_i(bus_rdata_i));

    int total = 0, bad = 0;
    bit finished = 0;

    // target script
    int n_err, npoll, attempt, poll;
    bit ma, hang, both;
    logic [31:0] exp_op, last_err;
    int n_op, n_scr, n_rcr, n_any, bad_op, bad_scr, bad_rcr, bad_hold, first_we_addr;
    int wait_left = 0;
    logic [ADDR_W-1:0] hold_addr;
    logic [31:0] hold_wdata;
    logic hold_we;
    bit holding = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] noise();
        logic [31:0] v = $urandom;
        v[24] = 1'b0; v[6] = 1'b0; v[20] = 1'b0;
        return v;
    endfunction

    function automatic logic [31:0] scr_read();
        logic [31:0] v = noise();
        if (attempt < n_err) begin
            if (poll < npoll) begin poll++; return v; end
            poll = 0; attempt++;
            v[6] = 1'b1; v[20] = ma;
            last_err = v;
            return v;
        end
        if (hang) return v;
        if (poll < npoll) begin poll++; return v; end
        v[24] = 1'b1; v[6] = both;
        return v;
    endfunction

    // bus target: acks at negedges, random wait states
    initial begin
        forever begin
            @(negedge clk);
            if (bus_ack_i) begin
                bus_ack_i = 1'b0;
                holding = 0;
            end else if (bus_req_o) begin
                if (holding && (hold_addr != bus_addr_o || hold_we != bus_we_o
                                || hold_wdata != bus_wdata_o)) bad_hold++;
                holding = 1; hold_addr = bus_addr_o; hold_we = bus_we_o; hold_wdata = bus_wdata_o;
                if (wait_left > 0) wait_left--;
                else begin
                    wait_left = $urandom_range(0, 2);
                    bus_ack_i = 1'b1;
                    n_any++;
                    if (bus_we_o) begin
                        if (n_any == 1) first_we_addr = int'(bus_addr_o);
                        case (bus_addr_o)
                            12'h084: begin n_op++; if (bus_wdata_o != exp_op) bad_op++; end
                            12'h088: begin n_scr++; if (bus_wdata_o != (last_err & ~(32'd1 << 20))) bad_scr++; end
                            12'h090: begin n_rcr++; if (bus_wdata_o != 32'h4) bad_rcr++; end
                            default: bad_op++;
                        endcase
                        bus_rdata_i = '0;
                    end else begin
                        bus_rdata_i = (bus_addr_o == 12'h088) ? scr_read() : 32'h0;
                    end
                end
            end
        end
    end

    task automatic run_case(input logic [STAT_W-1:0] sin, input int ne, input int np,
                            input bit m, input bit h, input bit b, input int tmo,
                            input bit force_tmo, input bit restart);
        logic [STAT_W-1:0] exp_s;
        int cyc = 0;
        n_err = ne; npoll = np; ma = m; hang = h; both = b;
        attempt = 0; poll = 0; last_err = '0;
        n_op = 0; n_scr = 0; n_rcr = 0; n_any = 0; bad_op = 0; bad_scr = 0; bad_rcr = 0;
        bad_hold = 0; first_we_addr = -1;
        exp_op = $urandom;
        @(negedge clk);
        opcode_i = exp_op; status_in_i = sin; timeout_i = TMO_W'(tmo); start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        while (!done_o && cyc < 5000) begin
            if (restart && cyc == 4) begin
                opcode_i = ~exp_op; status_in_i = 3'b101; start_i = 1'b1;
            end else start_i = 1'b0;
            @(negedge clk);
            cyc++;
        end
        start_i = 1'b0;
        if (sin[2]) exp_s = sin;
        else if (h || force_tmo) exp_s = S_TMO;
        else if (ne >= 16) exp_s = S_ERR;
        else exp_s = sin;
        check(done_o == 1'b1, "R10 done seen", done_o, 1);
        check(status_o == exp_s, "R4/R7/R8 status", status_o, exp_s);
        if (sin[2]) begin
            check(cyc == 0, "R2 done next cycle", cyc, 0);
            check(n_any == 0, "R2 no bus access", n_any, 0);
        end else if (h || force_tmo) begin
            check(n_op >= 1 && n_rcr == n_op - 1, "R8 no retry after timeout", n_rcr, n_op - 1);
        end else begin
            int att = (ne >= 16) ? 16 : ne + 1;
            int errs = (ne >= 16) ? 16 : ne;
            check(n_op == att, "R3/R7 opcode writes", n_op, att);
            check(n_rcr == errs, "R6 clear-error writes", n_rcr, errs);
            check(n_scr == (m ? errs : 0), "R5 status write-backs", n_scr, m ? errs : 0);
            check(first_we_addr == 32'h084, "R3 first access", first_we_addr, 32'h084);
        end
        check(bad_op == 0, "R3/R10 opcode data", bad_op, 0);
        check(bad_scr == 0, "R5 write-back value", bad_scr, 0);
        check(bad_rcr == 0, "R6 clear-error value", bad_rcr, 0);
        check(bad_hold == 0, "R9 request held", bad_hold, 0);
        @(negedge clk);
        check(done_o == 1'b0, "R10 done one cycle", done_o, 0);
    endtask

    initial begin
        int cnt = 0;
        while (cnt < 150000 && !finished) begin @(posedge clk); cnt++; end
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected=%0d", cnt, 150000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7));
        repeat (3) @(negedge clk);
        check(done_o == 1'b0, "R1 reset done", done_o, 0);
        check(bus_req_o == 1'b0, "R1 reset req", bus_req_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(bus_req_o == 1'b0 && done_o == 1'b0, "R1 idle after reset", bus_req_o, 0);
        // directed corners
        run_case(3'b000, 0, 0, 0, 0, 0, 100000, 0, 0);   // R4 plain success
        run_case(3'b001, 0, 2, 0, 0, 1, 100000, 0, 0);   // R4 complete wins over error
        run_case(3'b101, 3, 1, 1, 0, 0, 100000, 0, 0);   // R2 pass-through
        run_case(3'b111, 0, 0, 0, 0, 0, 100000, 0, 0);   // R2
        run_case(3'b000, 2, 1, 1, 0, 0, 100000, 0, 0);   // R5 with memory-access
        run_case(3'b010, 2, 1, 0, 0, 0, 100000, 0, 0);   // R5 without
        run_case(3'b000, 15, 0, 1, 0, 0, 100000, 0, 0);  // R7 last attempt succeeds
        run_case(3'b000, 16, 1, 1, 0, 0, 100000, 0, 0);  // R7 exhaustion
        run_case(3'b000, 0, 0, 0, 0, 0, 0, 0, 0);        // R8 zero timeout, immediate complete
        run_case(3'b000, 1, 0, 0, 0, 0, 0, 1, 0);        // R8 zero timeout, error read
        run_case(3'b000, 0, 0, 0, 1, 0, 200, 0, 0);      // R8 hang
        run_case(3'b000, 16, 3, 0, 0, 0, 60, 1, 0);      // R8 deadline spans retries
        run_case(3'b000, 3, 2, 1, 0, 0, 100000, 0, 1);   // R10 start while busy ignored
        // random mix
        for (int i = 0; i < 40; i++) begin
            run_case(STAT_W'($urandom_range(0, 3)), $urandom_range(0, 17), $urandom_range(0, 3),
                     1'($urandom), 1'b0, 1'($urandom), 100000, 1'b0, 1'($urandom));
        end
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule